// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Registers

This block lets two processors wake each other through interrupts. Signalling runs both ways: one set of channels raises interrupts toward the application side and another set raises them toward the control side. Each direction has a low-priority channel (index 0) and a high-priority channel (index 1). Every channel holds a 32-bit doorbell status word. A sender posts a message by writing any nonzero command word to the channel's set port, and those bits are ORed into the status. The receiver acknowledges by writing a mask to the channel's clear port. The interrupt for a channel stays high as long as any bit of its status is set.

Each processor has its own register port. A port has an address, a write enable, write data and a registered read-data output, and both ports can reach every register. The sender knows its last message has been taken when a read of that channel's status returns zero. Payload memory and bus bridging are outside this block.

Top module: `doorbell_mailbox`

## Requirements
- R1: The register map is fixed. Channel c belongs to direction d = c/2 and has index n = c%2. Its status word sits at d*0x100 + n*0x20, its set port 0x8 above that and its clear port 0x10 above that. Direction 0 (base 0x000) drives `irq_to_app[n]`, and direction 1 (base 0x100) drives `irq_to_ctl[n]`.
- R2: A write to a set port ORs the write data into that channel's status word.
- R3: A write to a clear port clears every status bit that is 1 in the write data. Writing 0xFFFFFFFF returns the status to zero.
- R4: A channel's interrupt output is high exactly when its status is nonzero. It is registered, so it changes at the same clock edge as the status, one cycle after the write.
- R5: Either port can read any status word. Read data is registered: it appears after the edge at which the address is presented, and it shows the status as it was before any write taking effect at that edge.
- R6: A read of a set port, a clear port or any unmapped address returns zero.
- R7: A write to a status address or to an unmapped address changes no status word.
- R8: If a set and a clear hit the same bit in the same cycle, from either port, the bit ends up set. Sets from both ports in one cycle are ORed together.
- R9: A synchronous active-high reset zeroes every status word, every interrupt output and both read-data outputs.
- R10: Channels are independent. A write to one channel never changes another channel's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 12 | Application-side port byte address |
| a_we | input | 1 | Application-side write enable |
| a_wdata | input | 32 | Application-side write data |
| a_rdata | output | 32 | Application-side read data (registered) |
| b_addr | input | 12 | Control-side port byte address |
| b_we | input | 1 | Control-side write enable |
| b_wdata | input | 32 | Control-side write data |
| b_rdata | output | 32 | Control-side read data (registered) |
| irq_to_app | output | 2 | Interrupts toward the application side, one per channel |
| irq_to_ctl | output | 2 | Interrupts toward the control side, one per channel |

## Verification
A write presented in one cycle updates the status and the interrupt at the next rising edge. A read address presented in one cycle yields its data after that same edge. The bench drives every input at a falling edge and samples one falling edge later, so each result is read half a period after the edge that produced it. The interrupt-latency test also samples the interrupt before that edge, to show it has not yet risen. The same-edge test reads a status word while another port writes it, and expects the old value in return.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;

  // Per-channel address match flags produced by the decoder
  typedef struct packed {
    logic stat;
    logic set;
    logic clr;
  } hit_t;

  // Byte address of one register of a channel group
  function automatic int unsigned reg_addr(
    input int unsigned dir,
    input int unsigned idx,
    input int unsigned dir_stride,
    input int unsigned ch_stride,
    input int unsigned ofs
  );
    return dir * dir_stride + idx * ch_stride + ofs;
  endfunction

endpackage

// File: rtl/dbmb_decode.sv
module dbmb_decode
  import dbmb_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int CH_PER_DIR = 2,
  parameter int NUM_CH     = 4,
  parameter int DIR_STRIDE = 'h100,
  parameter int CH_STRIDE  = 'h20,
  parameter int SET_OFS    = 'h8,
  parameter int CLR_OFS    = 'h10
) (
  input  logic [ADDR_W-1:0]  addr,
  output hit_t [NUM_CH-1:0]  hits
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned DIR = c / CH_PER_DIR;
    localparam int unsigned IDX = c % CH_PER_DIR;
    localparam int unsigned A_STAT = reg_addr(DIR, IDX, DIR_STRIDE, CH_STRIDE, 0);
    localparam int unsigned A_SET  = reg_addr(DIR, IDX, DIR_STRIDE, CH_STRIDE, SET_OFS);
    localparam int unsigned A_CLR  = reg_addr(DIR, IDX, DIR_STRIDE, CH_STRIDE, CLR_OFS);

    always_comb begin
      hits[c].stat = (addr == ADDR_W'(A_STAT));
      hits[c].set  = (addr == ADDR_W'(A_SET));
      hits[c].clr  = (addr == ADDR_W'(A_CLR));
    end
  end

endmodule

// File: rtl/dbmb_cell.sv
module dbmb_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] status,
  output logic              irq
);

  logic [DATA_W-1:0] status_d;

  // Set takes priority over clear on the same bit
  always_comb status_d = (status & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |status_d;
    end
  end

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && !irq));

  // R4
  irq_tracks_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0));

  // R2 R8
  set_bits_land_chk: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> ((status & $past(set_mask)) == $past(set_mask)));

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_mask == '1 && set_mask == '0) |=> (status == '0));

  // R7 R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (set_mask == '0 && clr_mask == '0) |=> $stable(status));

endmodule

// File: rtl/dbmb_rdport.sv
module dbmb_rdport #(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CH-1:0]             sel,
  input  logic [NUM_CH-1:0][DATA_W-1:0] status,
  output logic [DATA_W-1:0]             rdata
);

  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      mux = mux | (status[c] & {DATA_W{sel[c]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux;
  end

  // R6
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> (rdata == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rd_chk
    // R5
    read_old_value_chk: assert property (@(posedge clk) disable iff (rst)
      sel[c] |=> (rdata == $past(status[c])));
  end

endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import dbmb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 12,
  parameter int CH_PER_DIR = 2,
  parameter int DIR_STRIDE = 'h100,
  parameter int CH_STRIDE  = 'h20,
  parameter int SET_OFS    = 'h8,
  parameter int CLR_OFS    = 'h10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     a_addr,
  input  logic                  a_we,
  input  logic [DATA_W-1:0]     a_wdata,
  output logic [DATA_W-1:0]     a_rdata,
  input  logic [ADDR_W-1:0]     b_addr,
  input  logic                  b_we,
  input  logic [DATA_W-1:0]     b_wdata,
  output logic [DATA_W-1:0]     b_rdata,
  output logic [CH_PER_DIR-1:0] irq_to_app,
  output logic [CH_PER_DIR-1:0] irq_to_ctl
);

  localparam int NUM_DIR = 2;
  localparam int NUM_CH  = NUM_DIR * CH_PER_DIR;

  hit_t [NUM_CH-1:0] a_hits, b_hits;
  logic [NUM_CH-1:0] a_stat_sel, b_stat_sel;
  logic [NUM_CH-1:0][DATA_W-1:0] status;
  logic [NUM_CH-1:0] irq;

  dbmb_decode #(
    .ADDR_W(ADDR_W), .CH_PER_DIR(CH_PER_DIR), .NUM_CH(NUM_CH),
    .DIR_STRIDE(DIR_STRIDE), .CH_STRIDE(CH_STRIDE),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_dec_a (
    .addr(a_addr),
    .hits(a_hits)
  );

  dbmb_decode #(
    .ADDR_W(ADDR_W), .CH_PER_DIR(CH_PER_DIR), .NUM_CH(NUM_CH),
    .DIR_STRIDE(DIR_STRIDE), .CH_STRIDE(CH_STRIDE),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_dec_b (
    .addr(b_addr),
    .hits(b_hits)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [DATA_W-1:0] set_mask, clr_mask;

    always_comb begin
      set_mask = ({DATA_W{a_we & a_hits[c].set}} & a_wdata)
               | ({DATA_W{b_we & b_hits[c].set}} & b_wdata);
      clr_mask = ({DATA_W{a_we & a_hits[c].clr}} & a_wdata)
               | ({DATA_W{b_we & b_hits[c].clr}} & b_wdata);
      a_stat_sel[c] = a_hits[c].stat;
      b_stat_sel[c] = b_hits[c].stat;
    end

    dbmb_cell #(.DATA_W(DATA_W)) u_cell (
      .clk(clk),
      .rst(rst),
      .set_mask(set_mask),
      .clr_mask(clr_mask),
      .status(status[c]),
      .irq(irq[c])
    );
  end

  dbmb_rdport #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rd_a (
    .clk(clk), .rst(rst), .sel(a_stat_sel), .status(status), .rdata(a_rdata)
  );

  dbmb_rdport #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_rd_b (
    .clk(clk), .rst(rst), .sel(b_stat_sel), .status(status), .rdata(b_rdata)
  );

  // Direction 0 signals the application side, direction 1 the control side
  assign irq_to_app = irq[CH_PER_DIR-1:0];
  assign irq_to_ctl = irq[NUM_CH-1:CH_PER_DIR];

  // R1
  a_decode_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_hits}));

  // R1
  b_decode_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({b_hits}));

endmodule

// File: tb/doorbell_mailbox_test.sv
module doorbell_mailbox_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [1:0]  irq_to_app, irq_to_ctl;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  doorbell_mailbox uut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_app(irq_to_app), .irq_to_ctl(irq_to_ctl)
  );

  function automatic logic [11:0] adr(input int ch, input int ofs);
    return 12'((ch / 2) * 'h100 + (ch % 2) * 'h20 + ofs);
  endfunction

  function automatic logic irq_of(input int ch);
    return (ch < 2) ? irq_to_app[ch] : irq_to_ctl[ch-2];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input bit port_b, input logic [11:0] ad, input logic [31:0] d);
    if (port_b) begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
    else        begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic wr2(input logic [11:0] aa, input logic [31:0] ad,
                     input logic [11:0] ba, input logic [31:0] bd);
    a_addr = aa; a_wdata = ad; a_we = 1'b1;
    b_addr = ba; b_wdata = bd; b_we = 1'b1;
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input bit port_b, input logic [11:0] ad, output logic [31:0] d);
    if (port_b) b_addr = ad; else a_addr = ad;
    @(negedge clk);
    d = port_b ? b_rdata : a_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9", "a_rdata after reset", a_rdata, 32'h0);
    check("R9", "b_rdata after reset", b_rdata, 32'h0);
    check("R9", "irq_to_app after reset", {30'h0, irq_to_app}, 32'h0);
    check("R9", "irq_to_ctl after reset", {30'h0, irq_to_ctl}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(1'b0, adr(c, 0), v);
      check("R9", "status after reset", v, 32'h0);
    end
  endtask

  task automatic t_map();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      logic [31:0] pat = 32'hA5000001 + 32'(c) * 32'h01010101;
      wr(1'b1, adr(c, 'h8), pat);
      for (int o = 0; o < 4; o++) begin
        rd(1'b0, adr(o, 0), v);
        check("R10", "status read via port a", v, (o == c) ? pat : 32'h0);
        check("R1", "irq placement", {31'h0, irq_of(o)}, {31'h0, o == c});
      end
      rd(1'b1, adr(c, 0), v);
      check("R5", "status read via port b", v, pat);
      wr(1'b0, adr(c, 'h10), 32'hFFFFFFFF);
      check("R3", "irq dropped after full clear", {31'h0, irq_of(c)}, 32'h0);
    end
  endtask

  task automatic t_or_and_clear();
    logic [31:0] v;
    wr(1'b1, adr(1, 'h8), 32'h0000000F);
    wr(1'b1, adr(1, 'h8), 32'h000000F0);
    rd(1'b0, adr(1, 0), v);
    check("R2", "OR of two sets", v, 32'h000000FF);
    wr(1'b0, adr(1, 'h10), 32'h0000000F);
    rd(1'b0, adr(1, 0), v);
    check("R3", "partial clear", v, 32'h000000F0);
    check("R4", "irq held while bits remain", {31'h0, irq_to_app[1]}, 32'h1);
    wr(1'b0, adr(1, 'h10), 32'hFFFFFFFF);
    rd(1'b0, adr(1, 0), v);
    check("R3", "full clear", v, 32'h0);
    check("R4", "irq low after full clear", {31'h0, irq_to_app[1]}, 32'h0);
  endtask

  task automatic t_irq_timing();
    a_addr = adr(2, 'h8); a_wdata = 32'h80000000; a_we = 1'b1;
    #5;
    check("R4", "irq before edge", {31'h0, irq_to_ctl[0]}, 32'h0);
    @(negedge clk);
    a_we = 1'b0;
    check("R4", "irq one cycle after set", {31'h0, irq_to_ctl[0]}, 32'h1);
    b_addr = adr(2, 'h10); b_wdata = 32'h80000000; b_we = 1'b1;
    #5;
    check("R4", "irq before clear edge", {31'h0, irq_to_ctl[0]}, 32'h1);
    @(negedge clk);
    b_we = 1'b0;
    check("R4", "irq one cycle after clear", {31'h0, irq_to_ctl[0]}, 32'h0);
  endtask

  task automatic t_zero_reads();
    logic [31:0] v;
    wr(1'b0, adr(3, 'h8), 32'h12345678);
    rd(1'b1, adr(3, 'h8), v);
    check("R6", "read of set port", v, 32'h0);
    rd(1'b1, adr(3, 'h10), v);
    check("R6", "read of clear port", v, 32'h0);
    rd(1'b0, 12'h124, v);
    check("R6", "read of unmapped 0x124", v, 32'h0);
    rd(1'b0, 12'h200, v);
    check("R6", "read of unmapped 0x200", v, 32'h0);
    rd(1'b1, adr(3, 0), v);
    check("R5", "status still intact", v, 32'h12345678);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(1'b0, adr(3, 0), 32'hFFFFFFFF);
    wr(1'b1, 12'h128 + 12'h4, 32'hFFFFFFFF);
    wr(1'b0, 12'h300, 32'hFFFFFFFF);
    wr(1'b1, 12'h018, 32'hFFFFFFFF);
    rd(1'b0, adr(3, 0), v);
    check("R7", "status after ignored writes", v, 32'h12345678);
    for (int c = 0; c < 3; c++) begin
      rd(1'b1, adr(c, 0), v);
      check("R7", "other status after ignored writes", v, 32'h0);
    end
    wr(1'b0, adr(3, 'h10), 32'hFFFFFFFF);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(1'b0, adr(0, 'h8), 32'h0000FF00);
    wr2(adr(0, 'h10), 32'hFFFFFFFF, adr(0, 'h8), 32'h00000001);
    rd(1'b0, adr(0, 0), v);
    check("R8", "set beats same-cycle clear", v, 32'h00000001);
    check("R8", "irq stays high", {31'h0, irq_to_app[0]}, 32'h1);
    wr2(adr(0, 'h8), 32'h00F00000, adr(0, 'h8), 32'h0F000000);
    rd(1'b1, adr(0, 0), v);
    check("R8", "two sets ORed", v, 32'h0FF00001);
    wr(1'b1, adr(0, 'h10), 32'hFFFFFFFF);
  endtask

  task automatic t_read_old();
    logic [31:0] v;
    a_addr = adr(1, 0);
    b_addr = adr(1, 'h8); b_wdata = 32'h00000042; b_we = 1'b1;
    @(negedge clk);
    b_we = 1'b0;
    v = a_rdata;
    check("R5", "read during write returns old value", v, 32'h0);
    @(negedge clk);
    check("R5", "next read returns new value", a_rdata, 32'h00000042);
    wr(1'b0, adr(1, 'h10), 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_or_and_clear();
    t_irq_timing();
    t_zero_reads();
    t_ignored();
    t_race();
    t_read_old();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule